// File: doc/BRIEF.md
# Bus Controller Polling Sequencer

This block lets a bus controller walk a list of transactions held in host memory without the host touching each one. The host fills a stack with entries: a command word, a transaction word and, on request, a third word. It sets the control bits and writes a trigger code. The sequencer then fetches each entry over a single-outstanding memory port and loads it into the transaction registers. It starts the transaction and waits for a done/valid answer.

Per-entry flags choose whether a third word is fetched and whether the frame continues. Failed transactions are repeated up to a programmed count. After that the frame either halts or skips to the next entry, depending on the fault-override bit. A frame that ends on a valid last entry raises a poll-complete interrupt one cycle after the good-transfer interrupt. In continuous mode the frame then restarts from the programmed offset. The stack address of the entry in the registers stays readable, so a failed entry can be found.

Top module: `poll_sequencer`

## Requirements
- R1: The control register resets to 0 and reads back its writable bits: bit 0 bus-controller mode, bit 1 poll enable, bit 2 continuous, bit 3 fault override, bits 5:4 retry count. Bit 9 reads 1 exactly while a poll is running, and writes to it have no effect.
- R2: A trigger write is ignored unless control bits 0 and 1 are both set and no poll is running. An ignored trigger raises no memory request and leaves bit 9 at 0.
- R3: Trigger codes select the starting entry. Code 0x20 starts at the start-offset register. Code 0x22 clears the start-offset register to 0 and starts at address 0. Code 0x24 starts at the entry after the most recently loaded one.
- R4: For an entry at address p, the command word is read from p and the transaction word from p+1. If transaction-word bit 5 is 1, a third word is read from p+2 into the second-command register; otherwise that register keeps its value. A memory request holds its address stable until acknowledged.
- R5: Once an entry is loaded, xfer_start pulses for one cycle, and the command-word and second-command registers hold the loaded values.
- R6: A valid transaction whose transaction-word bit 6 is 1 is followed by the entry 2 words further on, or 3 words further on when bit 5 is 1. When bit 6 is 0, the frame ends.
- R7: A failed transaction is started again, with the same registers, up to the retry count in control bits 5:4.
- R8: When retries are exhausted, the poll halts if fault override is 0. If fault override is 1, the poll moves to the next entry, unless the failed entry is the last one, in which case it halts.
- R9: A frame whose last entry completes validly raises irq_pollcmp exactly one cycle after that entry's irq_good.
- R10: With continuous set, a completed frame restarts from the start-offset register. Clearing continuous during a frame ends the poll at that frame's completion.
- R11: The last-transaction output holds the stack address of the entry most recently loaded, and it keeps that value after the poll stops.
- R12: irq_good and irq_bad pulse once per transaction result, and no two interrupts are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| opr_wr | input | 1 | Control register write strobe |
| opr_wdata | input | 16 | Control register write data |
| opr_rdata | output | 16 | Control register readback including running flag |
| trig_wr | input | 1 | Trigger write strobe |
| trig_code | input | 8 | Trigger code |
| ofs_wr | input | 1 | Start-offset write strobe |
| ofs_wdata | input | AW | Start-offset write data |
| ofs_q | output | AW | Start-offset register |
| last_q | output | AW | Address of the most recently loaded entry |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_ack | input | 1 | Memory acknowledge, data valid |
| mem_rdata | input | 16 | Memory read data |
| cw1_q | output | 16 | Command word register |
| xw_q | output | 16 | Transaction word register |
| cw2_q | output | 16 | Second command / mode data register |
| xfer_start | output | 1 | One-cycle transaction start |
| xfer_done | input | 1 | Transaction finished |
| xfer_valid | input | 1 | Transaction result is good, sampled with done |
| irq_good | output | 1 | Good transfer interrupt pulse |
| irq_bad | output | 1 | Invalid transfer interrupt pulse |
| irq_pollcmp | output | 1 | Poll complete interrupt pulse |

## Verification
A wrong stack pointer or a lost third-word flag shows up at the next xfer_start: the command word, the second-command value or the last-transaction address differ from what a walk of the stack predicts. A wrong retry counter or halting rule shows up as a missing or extra transaction, and as wrong interrupt totals once the poll goes idle. A wrong completion path moves irq_pollcmp off the cycle after irq_good, or makes the continuous loop run one frame too many or too few. All of these appear within one transaction of the fault.

// File: rtl/poll_sequencer.sv
module poll_sequencer #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          opr_wr,
  input  logic [15:0]   opr_wdata,
  output logic [15:0]   opr_rdata,
  input  logic          trig_wr,
  input  logic [7:0]    trig_code,
  input  logic          ofs_wr,
  input  logic [AW-1:0] ofs_wdata,
  output logic [AW-1:0] ofs_q,
  output logic [AW-1:0] last_q,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] cw1_q,
  output logic [DW-1:0] xw_q,
  output logic [DW-1:0] cw2_q,
  output logic          xfer_start,
  input  logic          xfer_done,
  input  logic          xfer_valid,
  output logic          irq_good,
  output logic          irq_bad,
  output logic          irq_pollcmp
);
  typedef enum logic [2:0] {S_IDLE, S_FCW, S_FXW, S_FC2, S_GO, S_WAIT, S_CMPL} st_t;
  st_t st;
  logic [5:0]    ctl;
  logic [AW-1:0] ent, ofs;
  logic [1:0]    tries;

  wire bc_on   = ctl[0] & ctl[1];
  wire running = (st != S_IDLE);
  wire trig_ok = trig_wr & bc_on & ~running;
  wire [AW-1:0] nxt = ent + (xw_q[5] ? AW'(3) : AW'(2));

  assign opr_rdata  = {6'b0, running, 3'b0, ctl};
  assign ofs_q      = ofs;
  assign last_q     = ent;
  assign mem_req    = (st == S_FCW) | (st == S_FXW) | (st == S_FC2);
  assign mem_addr   = ent + ((st == S_FXW) ? AW'(1) : (st == S_FC2) ? AW'(2) : AW'(0));
  assign xfer_start = (st == S_GO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ctl <= '0; ent <= '0; ofs <= '0; tries <= '0;
      cw1_q <= '0; xw_q <= '0; cw2_q <= '0;
      irq_good <= 1'b0; irq_bad <= 1'b0; irq_pollcmp <= 1'b0;
    end else begin
      irq_good <= 1'b0; irq_bad <= 1'b0; irq_pollcmp <= 1'b0;
      if (opr_wr) ctl <= opr_wdata[5:0];
      if (ofs_wr) ofs <= ofs_wdata;
      case (st)
        S_IDLE: if (trig_ok) begin
          tries <= '0;
          case (trig_code)
            8'h20: begin ent <= ofs; st <= S_FCW; end
            8'h22: begin ent <= '0; ofs <= '0; st <= S_FCW; end
            8'h24: begin ent <= nxt; st <= S_FCW; end
            default: ;
          endcase
        end
        S_FCW: if (mem_ack) begin cw1_q <= mem_rdata; st <= S_FXW; end
        S_FXW: if (mem_ack) begin
          xw_q <= mem_rdata;
          st <= mem_rdata[5] ? S_FC2 : S_GO;
        end
        S_FC2: if (mem_ack) begin cw2_q <= mem_rdata; st <= S_GO; end
        S_GO:  st <= S_WAIT;
        S_WAIT: if (xfer_done) begin
          if (xfer_valid) begin
            irq_good <= 1'b1;
            if (xw_q[6]) begin ent <= nxt; tries <= '0; st <= S_FCW; end
            else st <= S_CMPL;
          end else begin
            irq_bad <= 1'b1;
            if (tries < ctl[5:4]) begin tries <= tries + 2'd1; st <= S_GO; end
            else if (ctl[3] && xw_q[6]) begin ent <= nxt; tries <= '0; st <= S_FCW; end
            else st <= S_IDLE;
          end
        end
        S_CMPL: begin
          irq_pollcmp <= 1'b1;
          if (ctl[2] && bc_on) begin ent <= ofs; tries <= '0; st <= S_FCW; end
          else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module poll_sequencer_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          xfer_start,
  input logic          irq_good,
  input logic          irq_bad,
  input logic          irq_pollcmp,
  input logic [15:0]   opr_rdata
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  assert_cmp_after_good_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pollcmp) |-> $past(irq_good));
  assert_irq_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_good, irq_bad, irq_pollcmp}));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !opr_rdata[9] |-> !mem_req && !xfer_start);
endmodule

bind poll_sequencer poll_sequencer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .xfer_start(xfer_start), .irq_good(irq_good),
  .irq_bad(irq_bad), .irq_pollcmp(irq_pollcmp), .opr_rdata(opr_rdata));

// File: tb/test_poll_sequencer.sv
module test_poll_sequencer;
  localparam int AW = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_a = 0, wr_b = 0;
  logic [15:0] wd_a = 0, wd_b = 0;
  logic opr_wr;
  logic [15:0] opr_wdata, opr_rdata;
  logic trig_wr = 0; logic [7:0] trig_code = 0;
  logic ofs_wr = 0; logic [AW-1:0] ofs_wdata = 0, ofs_q, last_q;
  logic mem_req, mem_ack = 0; logic [AW-1:0] mem_addr; logic [15:0] mem_rdata = 0;
  logic [15:0] cw1_q, xw_q, cw2_q;
  logic xfer_start, xfer_done = 0, xfer_valid = 0;
  logic irq_good, irq_bad, irq_pollcmp;

  assign opr_wr = wr_a | wr_b;
  assign opr_wdata = wr_b ? wd_b : wd_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  poll_sequencer #(.AW(AW)) i_poll_sequencer (.*);

  int n_cmp = 0, n_bad = 0;
  logic [15:0] mem [0:255];
  bit ok_q [0:255];
  int ri = 0, mi = 0;
  logic [15:0] e_cw [0:255], e_cw2 [0:255]; logic [AW-1:0] e_ent [0:255];
  int e_n = 0, e_good = 0, e_bad = 0, e_cmpl = 0;
  int ti = 0, g_cnt = 0, b_cnt = 0, c_cnt = 0, req_cnt = 0;
  logic [15:0] m_cw2 = 0;
  logic [AW-1:0] m_end = 0, m_step = 2;
  int cnt = 0;
  bit clr_on_cmp = 0;
  bit prev_good = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  always @(negedge clk) begin
    mem_ack <= mem_req && !mem_ack && ($urandom % 3 != 0);
    mem_rdata <= mem[mem_addr];
    if (mem_req) req_cnt++;
  end

  always @(negedge clk) begin
    xfer_done <= 0;
    if (xfer_start) begin
      if (ti < e_n) begin
        check(cw1_q == e_cw[ti], "R5 cw1", cw1_q, e_cw[ti]);
        check(cw2_q == e_cw2[ti], "R4 cw2", cw2_q, e_cw2[ti]);
        check(last_q == e_ent[ti], "R11 entry addr", last_q, e_ent[ti]);
      end else check(0, "R6 extra transaction", ti, e_n);
      ti++;
      cnt <= 1 + $urandom % 4;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin xfer_done <= 1; xfer_valid <= ok_q[ri]; ri++; end
    end
  end

  always @(negedge clk) begin
    wr_b <= 0;
    if (irq_good) g_cnt++;
    if (irq_bad) b_cnt++;
    if (irq_pollcmp) begin
      c_cnt++;
      check(prev_good, "R9 pollcmp after good", 0, 1);
      if (clr_on_cmp) begin wr_b <= 1; wd_b <= opr_rdata & 16'h003B; clr_on_cmp = 0; end
    end
    if (irq_good + irq_bad + irq_pollcmp > 1) check(0, "R12 exclusive", 1, 0);
    prev_good = irq_good;
  end

  function automatic int model_step(input logic [15:0] xw);
    return xw[5] ? 3 : 2;
  endfunction

  task automatic model(input logic [AW-1:0] start, input int frames, input logic [15:0] opr,
                       input logic [AW-1:0] ofs);
    logic [AW-1:0] p; int f; bit fin, good; logic [15:0] xw; int t;
    p = start; f = 0; fin = 0;
    e_n = 0; e_good = 0; e_bad = 0; e_cmpl = 0; mi = 0;
    while (!fin) begin
      xw = mem[p + 1];
      if (xw[5]) m_cw2 = mem[p + 2];
      t = 0; good = 0;
      forever begin
        e_cw[e_n] = mem[p]; e_cw2[e_n] = m_cw2; e_ent[e_n] = p; e_n++;
        if (ok_q[mi++]) begin e_good++; good = 1; break; end
        e_bad++;
        if (t < opr[5:4]) t++; else break;
      end
      m_end = p; m_step = AW'(model_step(xw));
      if (good) begin
        if (xw[6]) p = p + m_step;
        else begin e_cmpl++; f++; if (opr[2] && f < frames) p = ofs; else fin = 1; end
      end else if (opr[3] && xw[6]) p = p + m_step;
      else fin = 1;
    end
  endtask

  task automatic build(input int base, input int n);
    int a = base;
    for (int i = 0; i < n; i++) begin
      mem[a] = 16'($urandom); mem[a+1] = 16'($urandom) & 16'hFF9F;
      if ($urandom % 2) mem[a+1][5] = 1;
      if (i != n-1) mem[a+1][6] = 1;
      if (mem[a+1][5]) begin mem[a+2] = 16'($urandom); a += 3; end else a += 2;
    end
  endtask

  task automatic fill_ok(input int pct);
    for (int i = 0; i < 256; i++) ok_q[i] = ($urandom % 100) < pct;
    ri = 0; ti = 0; g_cnt = 0; b_cnt = 0; c_cnt = 0;
  endtask

  task automatic wr_opr(input logic [15:0] v);
    @(negedge clk); wr_a = 1; wd_a = v; @(negedge clk); wr_a = 0;
  endtask

  task automatic wr_ofs(input logic [AW-1:0] v);
    @(negedge clk); ofs_wr = 1; ofs_wdata = v; @(negedge clk); ofs_wr = 0;
  endtask

  task automatic trig(input logic [7:0] c);
    @(negedge clk); trig_wr = 1; trig_code = c; @(negedge clk); trig_wr = 0;
  endtask

  task automatic run_and_check(input logic [7:0] code, input string tag);
    int w = 0;
    trig(code);
    while (opr_rdata[9] && w < 20000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    check(ti == e_n, {tag, " transaction count"}, ti, e_n);
    check(g_cnt == e_good, "R12 good irqs", g_cnt, e_good);
    check(b_cnt == e_bad, "R7 bad irqs", b_cnt, e_bad);
    check(c_cnt == e_cmpl, "R10 complete irqs", c_cnt, e_cmpl);
    check(last_q == m_end, "R11 last address", last_q, m_end);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] op; logic [AW-1:0] o;
    void'($urandom(32'd1553));
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    check(opr_rdata == 0, "R1 reset opr", opr_rdata, 0);
    check(last_q == 0 && ofs_q == 0, "R11 reset regs", last_q, 0);

    wr_opr(16'h023E);
    check(opr_rdata == 16'h003E, "R1 readback", opr_rdata, 16'h003E);

    req_cnt = 0; fill_ok(100);
    wr_opr(16'h0002); trig(8'h20); repeat (10) @(negedge clk);
    check(req_cnt == 0 && !opr_rdata[9], "R2 no bc mode", req_cnt, 0);
    wr_opr(16'h0001); trig(8'h22); repeat (10) @(negedge clk);
    check(req_cnt == 0 && !opr_rdata[9], "R2 no enable", req_cnt, 0);

    wr_ofs(8'd40); build(0, 3); fill_ok(100);
    wr_opr(16'h0003); model(0, 1, 16'h0003, 0);
    run_and_check(8'h22, "R3 code22");
    check(ofs_q == 0, "R3 offset cleared", ofs_q, 0);

    for (int k = 0; k < 8; k++) begin
      o = AW'(10 + $urandom % 150);
      op = 16'h0003 | (16'($urandom % 4) << 4) | (($urandom % 2) ? 16'h8 : 16'h0);
      build(o, 1 + $urandom % 5); fill_ok(60);
      wr_ofs(o); wr_opr(op); model(o, 1, op, o);
      run_and_check(8'h20, "R6 random");
    end

    build(200, 3); mem[201][6] = 1; fill_ok(100); ok_q[0] = 0;
    wr_ofs(200); wr_opr(16'h0003); model(200, 1, 16'h0003, 200);
    run_and_check(8'h20, "R8 halt");
    fill_ok(100); model(m_end + m_step, 1, 16'h0003, 200);
    run_and_check(8'h24, "R3 continue");

    build(120, 3); fill_ok(100);
    wr_ofs(120); wr_opr(16'h0007); model(120, 2, 16'h0007, 120);
    clr_on_cmp = 1;
    run_and_check(8'h20, "R10 continuous");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule